// File: doc/BRIEF.md
# SPI Slave with Buffered Transmit

This block is a byte-wide serial peripheral slave for a synchronous system. A host inside the chip writes the next byte to send into a holding register. It reads each received byte from a receive register and watches two flags: transmit-empty and receive-full. On the serial side an external master drives the serial clock, the master-out data line and an active-low select. The block returns data on the slave-out line, with a separate output-enable for the pad so that the line floats when the slave is not selected.

Clock polarity and clock phase are chosen by two static configuration inputs. With phase 0, the falling edge of select starts a byte and puts its first bit on the line at once, and every byte needs its own select pulse. With phase 1, the first clock edge of a byte launches data, and select may stay low across several bytes. In both modes a transfer that has started uses its own copy of the byte. A host write during the transfer waits in the holding register and is sent with the next byte.

All serial pins are brought into the system clock domain through flop-chain synchronisers. The system clock must run at least four times faster than the serial clock.

Top module: `spi_slave_buf`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0 and miso_oe is 0.
- R2: Each byte is 8 bits, most significant bit first, on both mosi and miso. With cfg_cpol=0 the serial clock idles low and its leading edge is rising. With cfg_cpol=1 it idles high and its leading edge is falling.
- R3: With cfg_cpha=0, a select falling edge copies the holding register into the shift path and puts bit 7 on miso before the first clock edge. mosi is captured on each leading edge. The next bit is presented on each trailing edge.
- R4: With cfg_cpha=1, miso changes on the leading edge: the first leading edge of a byte loads the holding register and presents bit 7. mosi is captured on trailing edges. Select may stay low, and the next leading edge then starts the next byte.
- R5: With cfg_cpha=0, further clock edges after the 8th capture, with select still low, start no new byte. A byte written meanwhile stays in the holding register and tx_empty stays 0.
- R6: A host write during a transfer does not alter the bits of the byte in flight. The written value is held and is sent as the next byte.
- R7: tx_empty goes to 1 when the holding register is copied into the shift path. A host write (wr_en) clears it to 0.
- R8: After the 8th capture, rd_data holds the received byte and rx_full is 1. A read strobe (rd_en) clears rx_full.
- R9: If select rises before 8 captures, the partial byte is discarded: rx_full stays 0, rd_data keeps its old value, and the next byte is counted from its first bit.
- R10: miso_oe is 1 only while select is low. It follows the pin with a latency of SYNC_STAGES+1 system clocks, and drops to 0 within that latency after select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level (static during a transfer) |
| cfg_cpha | input | 1 | Clock phase select (static during a transfer) |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Host read strobe, clears rx_full |
| rd_data | output | DATA_W | Last complete received byte |
| tx_empty | output | 1 | Holding register has been consumed |
| rx_full | output | 1 | Unread received byte available |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master (pad data) |
| miso_oe | output | 1 | Pad output enable for miso |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2. It holds each serial clock level for eight system clocks, so the three-cycle pin-to-action latency always settles before a sample is taken. These values make all four polarity and phase pairings reachable, as well as a write that lands in the middle of a byte, back-to-back bytes under one select, extra clock edges after a complete phase-0 byte, and a select that is released after three bits.

// File: rtl/spi_slave_pkg.sv
// Package: shared constants and types for the SPI slave.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package spi_slave_pkg;

    // Serial clock edges, classified by role for the selected polarity.
    typedef struct packed {
        logic lead;   // first edge after idle
        logic trail;  // return to idle level
    } sck_evt_t;

    // Map the raw rising and falling edges onto leading and trailing roles.
    function automatic sck_evt_t classify_edges(input logic cpol,
                                                input logic rise,
                                                input logic fall);
        sck_evt_t e;
        e.lead  = cpol ? fall : rise;
        e.trail = cpol ? rise : fall;
        return e;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings WIDTH asynchronous pins into the clk domain through STAGES flops
// each, and flags rising and falling edges on the synchronised levels.
// Assumes: each pin stays stable for at least STAGES+1 clk cycles.
// RESET_VAL gives the idle level, so that no edge is seen after reset.
module spi_pin_sync #(
    parameter int unsigned WIDTH     = 3,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] prev_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        // Shift the pin through its synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RESET_VAL[b]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_in[b]};
            end
        end

        assign level[b] = chain_q[STAGES-1];
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RESET_VAL;
        end else begin
            prev_q <= level;
        end
    end

    // Edges are the differences between the current and previous levels.
    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
    end

endmodule

// File: rtl/spi_shift_engine.sv
// Module: spi_shift_engine
// Serial state of the slave: the transmit shift path, the receive shift path,
// the bit counter and the pad enable. A byte starts on a select fall
// (phase 0) or on the first leading edge (phase 1). From then on the engine
// works on its own copy of the byte.
// Assumes: edge and level inputs are already synchronised to clk, and
// cpol/cpha stay static while select is low.
module spi_shift_engine
    import spi_slave_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sel_level_n,
    input  logic              sel_fall,
    input  logic              sel_rise,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_load,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_done,
    output logic              miso,
    output logic              miso_oe
);

    localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              in_byte_q;
    logic              out_bit_q;
    logic              oe_q;

    sck_evt_t evt;
    logic     active;
    logic     sel_edge;
    logic     sample_evt;
    logic     shift_evt;

    // Classify the clock edges and derive the per-cycle events.
    always_comb begin
        evt        = classify_edges(cpol, sck_rise, sck_fall);
        active     = !sel_level_n;
        sel_edge   = sel_fall | sel_rise;
        sample_evt = active && !sel_edge && in_byte_q && (cpha ? evt.trail : evt.lead);
        shift_evt  = active && !sel_edge && in_byte_q && (cpha ? evt.lead : evt.trail);
        tx_load    = !sel_rise &&
                     ((sel_fall && !cpha) ||
                      (active && !sel_edge && cpha && evt.lead && !in_byte_q));
        rx_word    = {rx_sh_q[DATA_W-2:0], mosi_s};
        rx_done    = sample_evt && (bitcnt_q == LAST_BIT);
    end

    // Advance the serial state on select and clock events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            bitcnt_q  <= '0;
            in_byte_q <= 1'b0;
            out_bit_q <= 1'b0;
            oe_q      <= 1'b0;
        end else if (sel_rise) begin
            in_byte_q <= 1'b0;
            bitcnt_q  <= '0;
            oe_q      <= 1'b0;
        end else begin
            if (sel_fall) begin
                oe_q      <= 1'b1;
                bitcnt_q  <= '0;
                in_byte_q <= 1'b0;
            end
            if (tx_load) begin
                out_bit_q <= tx_word[DATA_W-1];
                tx_sh_q   <= tx_word << 1;
                in_byte_q <= 1'b1;
                bitcnt_q  <= '0;
            end
            if (shift_evt) begin
                out_bit_q <= tx_sh_q[DATA_W-1];
                tx_sh_q   <= tx_sh_q << 1;
            end
            if (sample_evt) begin
                rx_sh_q <= rx_word;
                if (bitcnt_q == LAST_BIT) begin
                    bitcnt_q  <= '0;
                    in_byte_q <= 1'b0;
                end else begin
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end
        end
    end

    assign miso    = out_bit_q;
    assign miso_oe = oe_q;

endmodule

// File: rtl/spi_host_regs.sv
// Module: spi_host_regs
// System-side holding register for transmit, receive register and the two
// flags. When a host write and an engine load fall in the same cycle, the
// load takes the old value and the write is kept, with tx_empty left at 0.
// Assumes: single-cycle wr_en and rd_en strobes from the host.
module spi_host_regs #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              tx_load,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_word,
    output logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              rx_full
);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] rxbuf_q;
    logic              empty_q;
    logic              full_q;

    // Transmit holding register and its empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
        end else if (wr_en) begin
            hold_q  <= wr_data;
            empty_q <= 1'b0;
        end else if (tx_load) begin
            empty_q <= 1'b1;
        end
    end

    // Receive register and its full flag. A completed byte wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf_q <= '0;
            full_q  <= 1'b0;
        end else if (rx_done) begin
            rxbuf_q <= rx_word;
            full_q  <= 1'b1;
        end else if (rd_en) begin
            full_q <= 1'b0;
        end
    end

    assign tx_word  = hold_q;
    assign rd_data  = rxbuf_q;
    assign tx_empty = empty_q;
    assign rx_full  = full_q;

endmodule

// File: rtl/spi_slave_buf.sv
// Module: spi_slave_buf (top)
// SPI slave with a buffered transmit byte. It synchronises the serial pins,
// runs the shift engine and keeps the host registers.
// Assumes: clk runs at least 4x sck, cfg_cpol/cfg_cpha are static while
// selected, and the pad tri-states miso when miso_oe is 0.
module spi_slave_buf #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              rx_full,
    input  logic              sck,
    input  logic              mosi,
    input  logic              ss_n,
    output logic              miso,
    output logic              miso_oe
);

    localparam int unsigned PIN_W = 3;
    localparam int unsigned IDX_SCK = 0;
    localparam int unsigned IDX_MOSI = 1;
    localparam int unsigned IDX_SEL = 2;
    localparam logic [PIN_W-1:0] PIN_IDLE = 3'b100;

    logic [PIN_W-1:0]  pin_lvl;
    logic [PIN_W-1:0]  pin_rise;
    logic [PIN_W-1:0]  pin_fall;
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] rx_word;
    logic              tx_load;
    logic              rx_done;

    spi_pin_sync #(
        .WIDTH    (PIN_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in({ss_n, mosi, sck}),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    spi_shift_engine #(
        .DATA_W(DATA_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol       (cfg_cpol),
        .cpha       (cfg_cpha),
        .sck_rise   (pin_rise[IDX_SCK]),
        .sck_fall   (pin_fall[IDX_SCK]),
        .sel_level_n(pin_lvl[IDX_SEL]),
        .sel_fall   (pin_fall[IDX_SEL]),
        .sel_rise   (pin_rise[IDX_SEL]),
        .mosi_s     (pin_lvl[IDX_MOSI]),
        .tx_word    (tx_word),
        .tx_load    (tx_load),
        .rx_word    (rx_word),
        .rx_done    (rx_done),
        .miso       (miso),
        .miso_oe    (miso_oe)
    );

    spi_host_regs #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .tx_load (tx_load),
        .rx_done (rx_done),
        .rx_word (rx_word),
        .tx_word (tx_word),
        .rd_data (rd_data),
        .tx_empty(tx_empty),
        .rx_full (rx_full)
    );

endmodule

// File: rtl/spi_slave_buf_chk.sv
// Module: spi_slave_buf_chk
// Assertion checker bound to spi_slave_buf. It watches the flags, the
// receive register and the pad enable against the host strobes and the
// internal load and completion pulses.
module spi_slave_buf_chk #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              ss_n,
    input logic              tx_load,
    input logic              rx_done,
    input logic [DATA_W-1:0] rd_data,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              miso_oe
);

    logic [3:0] hi_cnt_q;

    // Count consecutive cycles with select high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (!ss_n) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != 4'hF) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    a_r10_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt_q >= 4'(SYNC_STAGES + 2)) |-> !miso_oe);

    a_r7_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_empty);

    a_r7_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !wr_en) |=> tx_empty);

    a_r8_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_full);

    a_r8_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rx_done) |=> !rx_full);

    a_r9_rd_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(rd_data));

endmodule

bind spi_slave_buf spi_slave_buf_chk #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .ss_n    (ss_n),
    .tx_load (tx_load),
    .rx_done (rx_done),
    .rd_data (rd_data),
    .tx_empty(tx_empty),
    .rx_full (rx_full),
    .miso_oe (miso_oe)
);

// File: tb/spi_slave_buf_test.sv
// Bench for spi_slave_buf. It drives a behavioural serial master. A
// reference model keeps the expected holding register, flags and receive
// byte, plus a queue of the miso bits still to come. The outputs are
// compared at the end of every settled step.
module spi_slave_buf_test;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0;
    logic       cfg_cpha = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tx_empty;
    logic       rx_full;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       ss_n = 1'b1;
    logic       miso;
    logic       miso_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    logic [7:0] m_hold = '0;
    bit         m_empty = 1;
    bit         m_full = 0;
    logic [7:0] m_rx = '0;
    bit         m_bits[$];

    spi_slave_buf uut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .sck(sck), .mosi(mosi),
        .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cmp_flags(input string req);
        chk({req, " tx_empty"}, int'(tx_empty), int'(m_empty));
        chk({req, " rx_full"}, int'(rx_full), int'(m_full));
        chk({req, " rd_data"}, int'(rd_data), int'(m_rx));
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_hold = v; m_empty = 0;
    endtask

    task automatic host_read();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        m_full = 0;
    endtask

    // Model the copy of the holding register into the shift path.
    task automatic model_load();
        m_empty = 1;
        for (int k = 7; k >= 0; k--) m_bits.push_back(m_hold[k]);
    endtask

    task automatic check_next_bit(input string req);
        bit e;
        e = m_bits.pop_front();
        chk({req, " miso bit"}, int'(miso), int'(e));
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        ss_n = 1'b1; cfg_cpol = pol; cfg_cpha = pha; sck = pol;
        step();
    endtask

    task automatic sel_fall();
        ss_n = 1'b0;
        m_bits.delete();
        if (!cfg_cpha) model_load();
        step();
        chk("R10 oe on select", int'(miso_oe), 1);
        if (!cfg_cpha) begin
            check_next_bit("R3 msb before first edge");
            chk("R7 empty after select load", int'(tx_empty), 1);
        end
    endtask

    task automatic sel_rise();
        ss_n = 1'b1;
        step();
        chk("R10 oe off after select", int'(miso_oe), 0);
    endtask

    // One byte (or a partial one) from the master side.
    task automatic run_byte(input logic [7:0] mo, input int nbits,
                            input bit mid_wr, input logic [7:0] mid_val);
        for (int i = 0; i < nbits; i++) begin
            if (!cfg_cpha) begin
                mosi = mo[7-i];
                repeat (2) @(negedge clk);
                sck = ~cfg_cpol; step();
                sck = cfg_cpol; step();
                if (i < 7) check_next_bit("R2 R3 trailing shift");
            end else begin
                if (i == 0) begin
                    model_load();
                end
                sck = ~cfg_cpol; step();
                check_next_bit("R2 R4 leading shift");
                if (i == 0) chk("R4 R7 empty on first lead", int'(tx_empty), 1);
                mosi = mo[7-i];
                repeat (2) @(negedge clk);
                sck = cfg_cpol; step();
            end
            if (mid_wr && i == 3) begin
                host_write(mid_val);
                chk("R6 R7 write mid transfer", int'(tx_empty), 0);
            end
        end
        if (nbits == 8) begin
            m_rx = mo; m_full = 1;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 rx_full", int'(rx_full), 0);
        chk("R1 miso_oe", int'(miso_oe), 0);

        // Mode pol 0 / pha 0
        set_mode(1'b0, 1'b0);
        host_write(8'hA5);
        chk("R7 write clears empty", int'(tx_empty), 0);
        sel_fall();
        run_byte(8'h3C, 8, 0, 8'h00);
        cmp_flags("R8 byte pol0 pha0");
        sel_rise();
        host_read();
        cmp_flags("R8 read clears full");

        // Mode pol 1 / pha 0 with a write inside the byte
        set_mode(1'b1, 1'b0);
        host_write(8'h5A);
        sel_fall();
        run_byte(8'hF0, 8, 1, 8'hC3);
        cmp_flags("R6 held byte pol1 pha0");
        sel_rise();
        host_read();
        sel_fall();
        run_byte(8'h0F, 8, 0, 8'h00);
        cmp_flags("R6 next byte sends held value");
        // Extra edges after the byte, select still low
        host_write(8'h11);
        for (int j = 0; j < 2; j++) begin
            sck = ~cfg_cpol; step();
            sck = cfg_cpol; step();
        end
        chk("R5 no new byte without select", int'(tx_empty), 0);
        cmp_flags("R5 flags after extra edges");
        sel_rise();
        host_read();

        // Mode pol 0 / pha 1, two bytes under one select
        set_mode(1'b0, 1'b1);
        host_write(8'h96);
        sel_fall();
        run_byte(8'h81, 8, 1, 8'h69);
        cmp_flags("R4 first byte pha1");
        host_read();
        run_byte(8'h7E, 8, 0, 8'h00);
        cmp_flags("R4 second byte same select");
        sel_rise();
        host_read();

        // Mode pol 1 / pha 1
        set_mode(1'b1, 1'b1);
        host_write(8'hE7);
        sel_fall();
        run_byte(8'h24, 8, 0, 8'h00);
        cmp_flags("R2 R4 byte pol1 pha1");
        sel_rise();
        host_read();

        // Select released after three bits
        set_mode(1'b0, 1'b0);
        host_write(8'h42);
        sel_fall();
        run_byte(8'hFF, 3, 0, 8'h00);
        sel_rise();
        cmp_flags("R9 partial byte discarded");
        host_write(8'h99);
        sel_fall();
        run_byte(8'h55, 8, 0, 8'h00);
        cmp_flags("R9 counter restarts");
        sel_rise();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule